// File: doc/BRIEF.md
# Execute-Group Redirect and Squash Generator

This block sits at the tail of an out-of-order execute stage. Each cycle it is shown a group of up to `W` instructions that have just executed, one per slot. It walks the slots in order, decides which of them count as processed in this group, and reports them as complete. From the processed slots it picks at most one event that must redirect fetch. The event is either a mispredicted branch or a memory-ordering violation that a separate load-store unit reports. The chosen event becomes a one-cycle registered squash request carrying the sequence number from which younger work is discarded, together with the corrected next PC.

The walk ends at the first empty slot, or as soon as the number of live (non-squashed) instructions reaches the functional-unit budget `EXEC_W`. Squashed instructions still pass through as complete, but they use no budget and can never redirect. A mispredict redirect also reports the branch PC and the direction the branch really took. That direction is found by comparing the next PC with the PC plus the instruction size. Two counters keep totals: one for redirecting mispredicts that had been predicted taken, and one for ordering-violation redirects.

Top module: `exec_redirect_gen`

## Requirements
- R1: Slots are examined from slot 0 upward, and examination ends at the first slot whose `in_valid` bit is 0. One cycle later, `done_mask` bit i is 1 exactly for the slots that were examined.
- R2: A slot is examined only while fewer than `EXEC_W` live (valid, not squashed) slots have been examined before it. Squashed slots use none of this budget.
- R3: An examined squashed slot is reported in `done_mask`. It never raises a redirect, whatever its mispredict, load or store bits say.
- R4: Among the examined live slots, only the lowest-numbered one that has a qualifying event raises a redirect. Events in higher slots of the same group have no effect on any output.
- R5: A live slot qualifies by mispredict when `in_mispred` is 1. It qualifies by ordering violation when `mo_viol` is 1 and the slot is a load or a store. If both hold, the mispredict wins. `redir_branch` and `redir_memord` are never 1 together.
- R6: A mispredict redirect sets `redirect` and `redir_branch`, and outputs that slot's sequence number, PC and next PC on `redir_seq`, `redir_mis_pc` and `redir_npc`.
- R7: On a mispredict redirect, `redir_taken` is 1 exactly when the slot's next PC differs from its PC plus `INSN_BYTES` (default 4).
- R8: An ordering-violation redirect sets `redirect` and `redir_memord`. It outputs that slot's sequence number and next PC, and passes `mo_load_seq` to `redir_load_seq`. `redir_mis_pc` is 0, and `redir_branch` and `redir_taken` are 0.
- R9: All outputs are registered and appear on the clock edge that samples the group. When a group has no redirect, `redirect` and every redirect field read 0 in the following cycle.
- R10: `cnt_taken_wrong` increments by one for each mispredict redirect whose slot had `in_pred_taken` = 1.
- R11: `cnt_memord` increments by one for each ordering-violation redirect.
- R12: While `rst` is high at a clock edge, all outputs, including both counters, are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | W | Slot holds an executed instruction |
| in_squashed | input | W | Slot instruction was already squashed |
| in_load | input | W | Slot instruction is a load |
| in_store | input | W | Slot instruction is a store |
| in_pred_taken | input | W | Branch in slot was predicted taken |
| in_mispred | input | W | Branch in slot was mispredicted |
| in_pc | input | W*PC_W | PC per slot, slot i at bits i*PC_W upward |
| in_npc | input | W*PC_W | Resolved next PC per slot |
| in_seq | input | W*SEQ_W | Sequence number per slot |
| mo_viol | input | 1 | Load-store unit reports an ordering violation this cycle |
| mo_load_seq | input | SEQ_W | Sequence number of the violating load |
| done_mask | output | W | Slots reported complete for the last group |
| redirect | output | 1 | One-cycle squash and fetch-redirect request |
| redir_seq | output | SEQ_W | Sequence number of the redirecting instruction |
| redir_mis_pc | output | PC_W | PC of the mispredicted branch |
| redir_npc | output | PC_W | Corrected next PC |
| redir_branch | output | 1 | Redirect is caused by a branch mispredict |
| redir_taken | output | 1 | Actual direction of the mispredicted branch |
| redir_memord | output | 1 | Redirect is caused by an ordering violation |
| redir_load_seq | output | SEQ_W | Violating load sequence number |
| cnt_taken_wrong | output | CNT_W | Count of predicted-taken mispredict redirects |
| cnt_memord | output | CNT_W | Count of ordering-violation redirects |

## Verification
The bench builds the block with `W = 4` and `EXEC_W = 2`. With these values the functional-unit budget runs out inside a group, so the early stop of R2 occurs often and interacts with squashed slots. Each slot independently takes one of six roles: empty, squashed, plain, mispredict, memory access, or mispredict plus memory access. Every one of the 1296 role combinations is driven with the violation input both low and high. This covers every ordering of mispredicts, violations, gaps and squashed slots within a group. PCs and next PCs are varied so that both taken directions and both prediction values occur.

// File: rtl/erg_pkg.sv
package erg_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_BRANCH = 2'd1,
    EV_MEMORD = 2'd2
  } ev_kind_e;
endpackage

// File: rtl/erg_slot_scan.sv
module erg_slot_scan #(
  parameter int W      = 8,
  parameter int EXEC_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] valid_i,
  input  logic [W-1:0] squashed_i,
  output logic [W-1:0] take_o,
  output logic [W-1:0] live_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] BUDGET = CW'(EXEC_W);

  logic [W:0]    open_c;
  logic [CW-1:0] used_c [W+1];

  assign open_c[0] = 1'b1;
  assign used_c[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign take_o[i]   = open_c[i] & valid_i[i] & (used_c[i] < BUDGET);
    assign live_o[i]   = take_o[i] & ~squashed_i[i];
    assign open_c[i+1] = take_o[i];
    assign used_c[i+1] = used_c[i] + CW'(live_o[i]);
  end

  // R2
  fu_cap_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(live_o) <= EXEC_W);
endmodule

// File: rtl/erg_pick.sv
module erg_pick
  import erg_pkg::*;
#(
  parameter int W          = 8,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [W-1:0]       live_i,
  input  logic [W-1:0]       mispred_i,
  input  logic [W-1:0]       mem_i,
  input  logic               viol_i,
  input  logic [W-1:0]       pred_taken_i,
  input  logic [W*PC_W-1:0]  pc_i,
  input  logic [W*PC_W-1:0]  npc_i,
  input  logic [W*SEQ_W-1:0] seq_i,
  output ev_kind_e           kind_o,
  output logic [SEQ_W-1:0]   seq_o,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    npc_o,
  output logic               taken_o,
  output logic               pred_taken_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic [W-1:0] br_c, mo_c, first_c;
  logic [W:0]   seen_c;
  logic         is_br;

  assign seen_c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_prio
    assign br_c[i]      = live_i[i] & mispred_i[i];
    assign mo_c[i]      = live_i[i] & mem_i[i] & viol_i;
    assign first_c[i]   = (br_c[i] | mo_c[i]) & ~seen_c[i];
    assign seen_c[i+1]  = seen_c[i] | br_c[i] | mo_c[i];
  end

  always_comb begin
    seq_o        = '0;
    pc_o         = '0;
    npc_o        = '0;
    pred_taken_o = 1'b0;
    is_br        = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (first_c[i]) begin
        seq_o        = seq_i[i*SEQ_W +: SEQ_W];
        pc_o         = pc_i[i*PC_W +: PC_W];
        npc_o        = npc_i[i*PC_W +: PC_W];
        pred_taken_o = pred_taken_i[i];
        is_br        = br_c[i];
      end
    end
  end

  assign taken_o = (npc_o != (pc_o + STEP));
  assign kind_o  = !seen_c[W] ? EV_NONE : (is_br ? EV_BRANCH : EV_MEMORD);
endmodule

// File: rtl/erg_evcnt.sv
module erg_evcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  output logic [CNT_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else if (inc_i) q_o <= q_o + CNT_W'(1);
  end

  // R10 R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc_i |=> (q_o == CNT_W'($past(q_o) + CNT_W'(1))));
  // R10 R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(q_o));
endmodule

// File: rtl/exec_redirect_gen.sv
module exec_redirect_gen
  import erg_pkg::*;
#(
  parameter int W          = 8,
  parameter int EXEC_W     = 4,
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int INSN_BYTES = 4,
  parameter int CNT_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       in_valid,
  input  logic [W-1:0]       in_squashed,
  input  logic [W-1:0]       in_load,
  input  logic [W-1:0]       in_store,
  input  logic [W-1:0]       in_pred_taken,
  input  logic [W-1:0]       in_mispred,
  input  logic [W*PC_W-1:0]  in_pc,
  input  logic [W*PC_W-1:0]  in_npc,
  input  logic [W*SEQ_W-1:0] in_seq,
  input  logic               mo_viol,
  input  logic [SEQ_W-1:0]   mo_load_seq,
  output logic [W-1:0]       done_mask,
  output logic               redirect,
  output logic [SEQ_W-1:0]   redir_seq,
  output logic [PC_W-1:0]    redir_mis_pc,
  output logic [PC_W-1:0]    redir_npc,
  output logic               redir_branch,
  output logic               redir_taken,
  output logic               redir_memord,
  output logic [SEQ_W-1:0]   redir_load_seq,
  output logic [CNT_W-1:0]   cnt_taken_wrong,
  output logic [CNT_W-1:0]   cnt_memord
);
  logic [W-1:0]     take_c, live_c;
  ev_kind_e         kind_c;
  logic [SEQ_W-1:0] sel_seq;
  logic [PC_W-1:0]  sel_pc, sel_npc;
  logic             sel_taken, sel_pt;

  erg_slot_scan #(.W(W), .EXEC_W(EXEC_W)) u_scan (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (in_valid),
    .squashed_i (in_squashed),
    .take_o     (take_c),
    .live_o     (live_c)
  );

  erg_pick #(.W(W), .PC_W(PC_W), .SEQ_W(SEQ_W), .INSN_BYTES(INSN_BYTES)) u_pick (
    .live_i       (live_c),
    .mispred_i    (in_mispred),
    .mem_i        (in_load | in_store),
    .viol_i       (mo_viol),
    .pred_taken_i (in_pred_taken),
    .pc_i         (in_pc),
    .npc_i        (in_npc),
    .seq_i        (in_seq),
    .kind_o       (kind_c),
    .seq_o        (sel_seq),
    .pc_o         (sel_pc),
    .npc_o        (sel_npc),
    .taken_o      (sel_taken),
    .pred_taken_o (sel_pt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_mask      <= '0;
      redirect       <= 1'b0;
      redir_seq      <= '0;
      redir_mis_pc   <= '0;
      redir_npc      <= '0;
      redir_branch   <= 1'b0;
      redir_taken    <= 1'b0;
      redir_memord   <= 1'b0;
      redir_load_seq <= '0;
    end else begin
      done_mask      <= take_c;
      redirect       <= (kind_c != EV_NONE);
      redir_seq      <= (kind_c != EV_NONE) ? sel_seq : '0;
      redir_npc      <= (kind_c != EV_NONE) ? sel_npc : '0;
      redir_mis_pc   <= (kind_c == EV_BRANCH) ? sel_pc : '0;
      redir_branch   <= (kind_c == EV_BRANCH);
      redir_taken    <= (kind_c == EV_BRANCH) & sel_taken;
      redir_memord   <= (kind_c == EV_MEMORD);
      redir_load_seq <= (kind_c == EV_MEMORD) ? mo_load_seq : '0;
    end
  end

  erg_evcnt #(.CNT_W(CNT_W)) u_cnt_pt (
    .clk   (clk),
    .rst   (rst),
    .inc_i ((kind_c == EV_BRANCH) & sel_pt),
    .q_o   (cnt_taken_wrong)
  );

  erg_evcnt #(.CNT_W(CNT_W)) u_cnt_mo (
    .clk   (clk),
    .rst   (rst),
    .inc_i (kind_c == EV_MEMORD),
    .q_o   (cnt_memord)
  );

  // R5
  cause_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(redir_branch && redir_memord));
  // R6
  br_squash_chk: assert property (@(posedge clk) disable iff (rst)
    redir_branch |-> redirect);
  // R8
  mo_clean_chk: assert property (@(posedge clk) disable iff (rst)
    redir_memord |-> (redirect && redir_mis_pc == '0 && !redir_taken));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> (!redir_branch && !redir_memord && redir_seq == '0 && redir_npc == '0));
  // R11
  mo_count_chk: assert property (@(posedge clk) disable iff (rst)
    redir_memord |-> (cnt_memord == CNT_W'($past(cnt_memord) + CNT_W'(1))));
  // R3
  done_cover_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (done_mask != '0));
endmodule

// File: tb/sim_exec_redirect_gen.sv
`timescale 1ns/1ps
module sim_exec_redirect_gen;
  localparam int W = 4, EW = 2, PW = 32, SW = 8, IB = 4, CW = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] v, sq, ld, st, pt, mp;
  logic [W*PW-1:0] pc, npc;
  logic [W*SW-1:0] seq;
  logic viol;
  logic [SW-1:0] lseq;
  logic [W-1:0] done_mask;
  logic redirect, rbr, rtk, rmo;
  logic [SW-1:0] rseq, rlseq;
  logic [PW-1:0] rmpc, rnpc;
  logic [CW-1:0] cpt, cmo;

  int n_chk = 0, n_fail = 0;
  int e_pt = 0, e_mo = 0;

  always #4 clk = ~clk;

  exec_redirect_gen #(.W(W), .EXEC_W(EW), .PC_W(PW), .SEQ_W(SW),
                      .INSN_BYTES(IB), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .in_valid(v), .in_squashed(sq), .in_load(ld),
    .in_store(st), .in_pred_taken(pt), .in_mispred(mp), .in_pc(pc),
    .in_npc(npc), .in_seq(seq), .mo_viol(viol), .mo_load_seq(lseq),
    .done_mask(done_mask), .redirect(redirect), .redir_seq(rseq),
    .redir_mis_pc(rmpc), .redir_npc(rnpc), .redir_branch(rbr),
    .redir_taken(rtk), .redir_memord(rmo), .redir_load_seq(rlseq),
    .cnt_taken_wrong(cpt), .cnt_memord(cmo));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    v = '0; sq = '0; ld = '0; st = '0; pt = '0; mp = '0;
    pc = '0; npc = '0; seq = '0; viol = 1'b0; lseq = '0;
    repeat (3) @(posedge clk);
    #2;
    // R12 reset state
    chk(redirect == 0 && done_mask == 0 && rseq == 0 && rnpc == 0 && rmpc == 0,
        "R12", {redirect, done_mask}, 0);
    chk(cpt == 0 && cmo == 0, "R12", {cpt, cmo}, 0);
    rst = 1'b0;

    for (int code = 0; code < 1296; code++) begin
      for (int vi = 0; vi < 2; vi++) begin
        int k [W];
        int fu, hit, hbr, stop_w, sq_ev;
        logic [W-1:0] edone;
        logic [SW-1:0] eseq;
        logic [PW-1:0] enpc, empc;
        logic etk;
        int rem;
        rem = code;
        for (int s = 0; s < W; s++) begin
          k[s] = rem % 6;
          rem = rem / 6;
          v[s]  = (k[s] != 0);
          sq[s] = (k[s] == 1);
          mp[s] = (k[s] == 1) || (k[s] == 3) || (k[s] == 5);
          ld[s] = ((k[s] == 1) || (k[s] == 4) || (k[s] == 5)) && (s % 2 == 0);
          st[s] = ((k[s] == 1) || (k[s] == 4) || (k[s] == 5)) && (s % 2 == 1);
          pt[s] = ((code >> s) & 1) != vi;
          pc[s*PW +: PW]  = 32'h1000 + code * 16 + s * 4;
          npc[s*PW +: PW] = ((code + s) % 3 == 0) ? 32'h1000 + code * 16 + s * 4 + 4
                                                  : 32'h1000 + code * 16 + s * 4 + (s + 1) * 8 + 8;
          seq[s*SW +: SW] = SW'(code * 4 + s + vi);
        end
        viol = (vi == 1);
        lseq = SW'(code) ^ 8'h5a;

        // model
        fu = 0; hit = 0; hbr = 0; stop_w = 0; sq_ev = 0;
        edone = '0; eseq = '0; enpc = '0; empc = '0; etk = 0;
        for (int s = 0; s < W; s++) begin
          if (!v[s]) break;
          if (fu >= EW) begin stop_w = 1; break; end
          edone[s] = 1'b1;
          if (sq[s]) begin sq_ev = 1; continue; end
          fu++;
          if (!hit && (mp[s] || ((ld[s] || st[s]) && viol))) begin
            hit = 1;
            hbr = mp[s];
            eseq = seq[s*SW +: SW];
            enpc = npc[s*PW +: PW];
            if (mp[s]) begin
              empc = pc[s*PW +: PW];
              etk = ((npc[s*PW +: PW] - pc[s*PW +: PW]) != 32'd4);
              if (pt[s]) e_pt++;
            end else e_mo++;
          end
        end

        @(posedge clk);
        #2;
        chk(done_mask == edone, stop_w ? "R2" : "R1", done_mask, edone);
        chk(redirect == (hit != 0), sq_ev ? "R3" : "R4", redirect, hit);
        chk(rseq == eseq && rnpc == enpc, !hit ? "R9" : (hbr ? "R6" : "R8"),
            {rseq, rnpc}, {eseq, enpc});
        chk(rmpc == empc, hbr ? "R6" : "R8", rmpc, empc);
        chk(rbr == (hit && hbr) && rmo == (hit && !hbr), "R5",
            {rbr, rmo}, {(hit && hbr), (hit && !hbr)});
        chk(rtk == etk, "R7", rtk, etk);
        chk(rlseq == ((hit && !hbr) ? lseq : '0), "R8", rlseq,
            (hit && !hbr) ? lseq : '0);
        chk(cpt == CW'(e_pt), "R10", cpt, e_pt);
        chk(cmo == CW'(e_mo), "R11", cmo, e_mo);
      end
    end

    v = '0;
    @(posedge clk); #2;
    chk(redirect == 0 && done_mask == 0, "R9", {redirect, done_mask}, 0);
    rst = 1'b1;
    @(posedge clk); #2;
    chk(cpt == 0 && cmo == 0 && redirect == 0, "R12", {cpt, cmo}, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule